// File: doc/BRIEF.md
# Strap-Addressed SMBus Register Slave

This block is a two-wire serial slave that lets a host reach a small bank of general-purpose I/O control registers one byte at a time. It listens on a clock line and an open-drain data line. It recognises its own 7-bit address, and it turns write-byte and read-byte transfers into single-cycle strobes on a parallel register bus that the neighbouring I/O logic serves. Each transfer carries a register index.

The upper four address bits are fixed at binary 0011. The lowest three bits come from pins that the chip shares with general-purpose I/O. Those pins are sampled on every clock for as long as either reset is held: the power-on reset or the external active-low reset. When reset is released the last sampled value is frozen, and the pins become ordinary I/O again.

The slave answers two identification indexes by itself. It treats unused indexes as empty. When the host reads either of the two interrupt-status indexes, the slave pulses a dedicated read-clear strobe so that the I/O logic can clear that status.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 0011 followed by the latched three strap bits (strap bit 2 is the most significant). The eighth bit of the address byte is the read/write bit, where 1 means read.
- R2: The strap value is taken from `strapIn` while `porN` or `extRstN` is low. After both resets are high, later changes on `strapIn` do not alter the address the slave answers to.
- R3: After an address byte that does not match, the slave pulls SDA low for no acknowledge and for none of the following bits, until the next START.
- R4: A write transfer carries the address byte, the index byte and one data byte, and the slave acknowledges all three. It then pulses `regWrEn` for exactly one cycle with `regAddr` equal to the index and `regWrData` equal to the data byte. The pulse coincides with the data-byte acknowledge.
- R5: A read transfer is a write of the index, a repeated START, and the address byte with the read bit set. The slave returns one byte, most significant bit first. For indexes 00h-05h, 08h-0Dh and 10h-15h, that byte is the value of `regRdData` while `regAddr` holds the index.
- R6: Index 20h reads as 60h and index 21h reads as 12h, whatever the value of `regRdData`.
- R7: Indexes 06h-07h, 0Eh-0Fh, 16h-1Fh and every index above 21h read as 00h. A write to any of these, or to 20h or 21h, is acknowledged but produces no `regWrEn` pulse.
- R8: A read of index 10h pulses `rdClr[0]` for one cycle, and a read of index 11h pulses `rdClr[1]` for one cycle. A read of any other index pulses neither, and a write never does.
- R9: `sdaPullLow` is the only drive on SDA: 1 pulls the line low and 0 releases it. It changes only while SCL is low.
- R10: Any byte that follows the single data byte of a write transfer is not acknowledged and produces no further `regWrEn` pulse.
- R11: While either reset is low, `sdaPullLow`, `regWrEn` and `rdClr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| porN | input | 1 | Power-on reset, active low |
| extRstN | input | 1 | External reset, active low |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| strapIn | input | 3 | Shared pins that supply the low address bits during reset |
| regAddr | output | 8 | Register index presented to the I/O logic |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Data byte for the write strobe |
| regRdData | input | 8 | Read value returned by the I/O logic for `regAddr` |
| rdClr | output | 2 | One-cycle read-clear strobes for status indexes 10h and 11h |

## Verification
A table of transfers runs at one strapped address. It writes to live, reserved and identification indexes, and it reads from live, reserved, identification, status and out-of-range indexes. The bench's I/O model returns the index XOR A5h. That separates a value taken from the bus from a constant the slave supplies itself, and it separates a strobe that fires from one that is suppressed. Directed transfers use a wrong upper nibble, a wrong strap value, a trailing extra byte, and a second strap value captured by the external reset. Together they show that the address comes from the latch rather than the live pins, and that acknowledge stops exactly where a transfer should end. A monitor counts every change of the SDA drive that occurs while SCL is high.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_IDX, ST_IDX_ACK,
    ST_DATA, ST_DATA_ACK, ST_TX, ST_TX_ACK, ST_HOLD
  } busState_t;

  typedef enum logic [1:0] {DRV_KEEP, DRV_ACK, DRV_REL} drvSel_t;

  typedef struct packed {
    logic    bitTick;
    logic    cntClr;
    logic    idxLoad;
    logic    wrFire;
    logic    txLoad;
    logic    txShift;
    drvSel_t drv;
  } ctrlStrobe_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic cntFull;
    logic addrMatch;
    logic rwBit;
    logic sdaLow;
  } busStatus_t;
endpackage

// File: rtl/smb_dpath.sv
module smb_dpath
  import smb_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0011,
  parameter logic [BYTE_W-1:0] ID_HI_IDX = 8'h20,
  parameter logic [BYTE_W-1:0] ID_HI_VAL = 8'h60,
  parameter logic [BYTE_W-1:0] ID_LO_VAL = 8'h12,
  parameter logic [BYTE_W-1:0] CLR_BASE  = 8'h10,
  parameter int CLR_N = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  ctrlStrobe_t        str,
  output busStatus_t         stat,
  output logic               sdaPullLow,
  output logic [BYTE_W-1:0]  regAddr,
  output logic               regWrEn,
  output logic [BYTE_W-1:0]  regWrData,
  input  logic [BYTE_W-1:0]  regRdData,
  output logic [CLR_N-1:0]   rdClr
);
  localparam logic [BYTE_W-1:0] ID_LO_IDX = ID_HI_IDX + 8'd1;

  logic sclQ, sclP, sdaQ, sdaP;
  logic [BYTE_W-1:0] rxReg, txReg, idxReg, rdByte;
  logic [CNT_W-1:0] bitCnt;
  logic sdaLow;
  logic [STRAP_W-1:0] addrLow;
  logic idxLive;

  function automatic logic isLive(input logic [BYTE_W-1:0] i);
    return (i <= 8'h05) || (i >= 8'h08 && i <= 8'h0D) || (i >= 8'h10 && i <= 8'h15);
  endfunction

  // line sampling and edge / condition detection
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclQ <= 1'b1; sclP <= 1'b1; sdaQ <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn; sclP <= sclQ; sdaQ <= sdaIn; sdaP <= sdaQ;
    end
  end

  // strap capture: follows the pins while any reset holds, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) addrLow <= strapIn;
  end

  assign idxLive = isLive(idxReg);

  always_comb begin
    if (idxReg == ID_HI_IDX)      rdByte = ID_HI_VAL;
    else if (idxReg == ID_LO_IDX) rdByte = ID_LO_VAL;
    else if (idxLive)             rdByte = regRdData;
    else                          rdByte = '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxReg <= '0; txReg <= '0; idxReg <= '0; bitCnt <= '0; sdaLow <= 1'b0;
    end else begin
      if (str.cntClr)       bitCnt <= '0;
      else if (str.bitTick) bitCnt <= bitCnt + CNT_W'(1);
      if (str.bitTick) rxReg <= {rxReg[BYTE_W-2:0], sdaQ};
      if (str.idxLoad) idxReg <= rxReg;
      if (str.txLoad) begin
        txReg  <= rdByte;
        sdaLow <= ~rdByte[BYTE_W-1];
      end else if (str.txShift) begin
        txReg  <= {txReg[BYTE_W-2:0], 1'b0};
        sdaLow <= ~txReg[BYTE_W-2];
      end else begin
        case (str.drv)
          DRV_ACK: sdaLow <= 1'b1;
          DRV_REL: sdaLow <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      regWrEn <= 1'b0; regWrData <= '0;
    end else begin
      regWrEn <= str.wrFire & idxLive;
      if (str.wrFire) regWrData <= rxReg;
    end
  end

  for (genvar g = 0; g < CLR_N; g++) begin : gClr
    always_ff @(posedge clk or posedge rst) begin
      if (rst) rdClr[g] <= 1'b0;
      else     rdClr[g] <= str.txLoad && (idxReg == CLR_BASE + BYTE_W'(g));
    end
  end

  assign stat.sclRise   = sclQ & ~sclP;
  assign stat.sclFall   = ~sclQ & sclP;
  assign stat.startSeen = sclQ & sclP & sdaP & ~sdaQ;
  assign stat.stopSeen  = sclQ & sclP & ~sdaP & sdaQ;
  assign stat.cntFull   = (bitCnt == CNT_W'(BYTE_W));
  assign stat.addrMatch = (rxReg[BYTE_W-1:1] == {ADDR_HI, addrLow});
  assign stat.rwBit     = rxReg[0];
  assign stat.sdaLow    = sdaLow;

  assign sdaPullLow = sdaLow;
  assign regAddr    = idxReg;

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaLow) |-> !$past(sclQ)); // R9
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(addrLow)); // R2
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn); // R4
  AST_WR_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> sdaLow); // R4
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|rdClr) |=> (rdClr == '0)); // R8
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  busStatus_t  stat,
  output ctrlStrobe_t str
);
  busState_t state, nxt;
  logic shifting;

  assign shifting = (state == ST_ADDR) || (state == ST_IDX) ||
                    (state == ST_DATA) || (state == ST_TX);

  always_comb begin
    nxt = state;
    str = '0;
    if (stat.startSeen) begin
      nxt = ST_ADDR;
      str.cntClr = 1'b1;
    end else if (stat.stopSeen) begin
      nxt = ST_IDLE;
    end else begin
      if (shifting && stat.sclRise && !stat.cntFull) str.bitTick = 1'b1;
      if (stat.sclFall) begin
        case (state)
          ST_ADDR: if (stat.cntFull) begin
            if (stat.addrMatch) begin nxt = ST_ADDR_ACK; str.drv = DRV_ACK; end
            else                begin nxt = ST_IDLE;     str.drv = DRV_REL; end
          end
          ST_ADDR_ACK: begin
            str.cntClr = 1'b1;
            if (stat.rwBit) begin nxt = ST_TX;  str.txLoad = 1'b1; end
            else            begin nxt = ST_IDX; str.drv = DRV_REL; end
          end
          ST_IDX: if (stat.cntFull) begin
            nxt = ST_IDX_ACK; str.drv = DRV_ACK; str.idxLoad = 1'b1;
          end
          ST_IDX_ACK: begin
            nxt = ST_DATA; str.cntClr = 1'b1; str.drv = DRV_REL;
          end
          ST_DATA: if (stat.cntFull) begin
            nxt = ST_DATA_ACK; str.drv = DRV_ACK; str.wrFire = 1'b1;
          end
          ST_DATA_ACK: begin
            nxt = ST_HOLD; str.drv = DRV_REL;
          end
          ST_TX: begin
            if (stat.cntFull) begin nxt = ST_TX_ACK; str.drv = DRV_REL; end
            else              str.txShift = 1'b1;
          end
          ST_TX_ACK: nxt = ST_HOLD;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !stat.sdaLow); // R3
  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && $past(state == ST_HOLD)) |-> !stat.sdaLow); // R10
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0011,
  parameter int CLR_N = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               extRstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [BYTE_W-1:0]  regAddr,
  output logic               regWrEn,
  output logic [BYTE_W-1:0]  regWrData,
  input  logic [BYTE_W-1:0]  regRdData,
  output logic [CLR_N-1:0]   rdClr
);
  logic rstAct;
  ctrlStrobe_t str;
  busStatus_t stat;

  assign rstAct = ~porN | ~extRstN;

  smb_ctrl uCtrl (
    .clk(clk), .rst(rstAct), .stat(stat), .str(str)
  );

  smb_dpath #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI), .CLR_N(CLR_N)) uDpath (
    .clk(clk), .rst(rstAct), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .str(str), .stat(stat), .sdaPullLow(sdaPullLow), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .rdClr(rdClr)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rstAct |=> (!sdaPullLow && !regWrEn && rdClr == '0) || !rstAct); // R11
endmodule

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [7:0] GPIO_KEY = 8'hA5;
  localparam int NVEC = 13;
  // {read, index, data}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 8'h01, 8'h5A}, {1'b0, 8'h0C, 8'h3C}, {1'b0, 8'h07, 8'h11},
    {1'b0, 8'h1F, 8'h22}, {1'b0, 8'h20, 8'h33}, {1'b1, 8'h03, 8'h00},
    {1'b1, 8'h0B, 8'h00}, {1'b1, 8'h20, 8'h00}, {1'b1, 8'h21, 8'h00},
    {1'b1, 8'h0E, 8'h00}, {1'b1, 8'h10, 8'h00}, {1'b1, 8'h11, 8'h00},
    {1'b1, 8'h30, 8'h00}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic porN, extRstN, sclM, sdaM, sdaLine, sdaPullLow, regWrEn;
  logic [2:0] strap;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [1:0] rdClr;

  assign sdaLine = sdaM & ~sdaPullLow;
  assign regRdData = regAddr ^ GPIO_KEY;

  smb_reg_slave uut (
    .clk(clk), .porN(porN), .extRstN(extRstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .strapIn(strap), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rdClr(rdClr)
  );

  int nRun = 0, nFail = 0;
  int wrCnt = 0, clr0Cnt = 0, clr1Cnt = 0, sdaViol = 0;
  logic [7:0] lastWa = 0, lastWd = 0;
  logic prevPull = 1'b0;

  always @(negedge clk) begin
    if (regWrEn) begin wrCnt++; lastWa = regAddr; lastWd = regWrData; end
    if (rdClr[0]) clr0Cnt++;
    if (rdClr[1]) clr1Cnt++;
  end

  always @(posedge clk) begin
    #1;
    if (sdaPullLow !== prevPull && sclM) sdaViol++;
    prevPull = sdaPullLow;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit liveIdx(input logic [7:0] i);
    return (i <= 8'h05) || (i >= 8'h08 && i <= 8'h0D) || (i >= 8'h10 && i <= 8'h15);
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] i);
    if (i == 8'h20) return 8'h60;
    if (i == 8'h21) return 8'h12;
    if (liveIdx(i)) return i ^ GPIO_KEY;
    return 8'h00;
  endfunction

  task automatic waitHalf;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1; sclM = 1; waitHalf; sdaM = 0; waitHalf; sclM = 0; waitHalf;
  endtask

  task automatic busRestart;
    sdaM = 1; waitHalf; sclM = 1; waitHalf; sdaM = 0; waitHalf; sclM = 0; waitHalf;
  endtask

  task automatic busStop;
    sdaM = 0; waitHalf; sclM = 1; waitHalf; sdaM = 1; waitHalf;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) begin
      sdaM = b[k]; waitHalf; sclM = 1; waitHalf; sclM = 0;
    end
    sdaM = 1; waitHalf; sclM = 1; waitHalf;
    ack = ~sdaLine;
    sclM = 0; waitHalf;
  endtask

  task automatic recvByte(output logic [7:0] b);
    sdaM = 1;
    for (int k = 7; k >= 0; k--) begin
      waitHalf; sclM = 1; waitHalf; b[k] = sdaLine; sclM = 0;
    end
    sdaM = 1; waitHalf; sclM = 1; waitHalf; sclM = 0; waitHalf;
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] i, input logic [7:0] d,
                         input bit extra, output bit ka, output bit ki, output bit kd,
                         output bit kx);
    busStart;
    sendByte({a, 1'b0}, ka);
    sendByte(i, ki);
    sendByte(d, kd);
    kx = 0;
    if (extra) sendByte(8'h88, kx);
    busStop;
  endtask

  task automatic doRead(input logic [6:0] a, input logic [7:0] i, output bit ka,
                        output bit ki, output bit kr, output logic [7:0] b);
    busStart;
    sendByte({a, 1'b0}, ka);
    sendByte(i, ki);
    busRestart;
    sendByte({a, 1'b1}, kr);
    recvByte(b);
    busStop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit ka, ki, kd, kx;
    logic [7:0] b;
    int w0, c0, c1;
    porN = 0; extRstN = 1; sclM = 1; sdaM = 1; strap = 3'b101;
    repeat (4) @(negedge clk);
    check("R11", "sdaPullLow in reset", sdaPullLow, 0);
    check("R11", "regWrEn in reset", regWrEn, 0);
    check("R11", "rdClr in reset", rdClr, 0);
    porN = 1;
    @(negedge clk);
    strap = 3'b000;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] idx, dat;
      idx = VECS[v][15:8]; dat = VECS[v][7:0];
      w0 = wrCnt; c0 = clr0Cnt; c1 = clr1Cnt;
      if (VECS[v][16]) begin
        doRead(7'h1D, idx, ka, ki, kd, b);
        check("R1", "read addr ack", ka, 1);
        check("R5", "index ack", ki, 1);
        check("R5", "read addr ack after restart", kd, 1);
        check(liveIdx(idx) ? "R5" : ((idx == 8'h20 || idx == 8'h21) ? "R6" : "R7"),
              "read byte", b, expRead(idx));
        check("R8", "rdClr0 count", clr0Cnt - c0, (idx == 8'h10) ? 1 : 0);
        check("R8", "rdClr1 count", clr1Cnt - c1, (idx == 8'h11) ? 1 : 0);
      end else begin
        doWrite(7'h1D, idx, dat, 0, ka, ki, kd, kx);
        check("R1", "write addr ack", ka, 1);
        check("R4", "index ack", ki, 1);
        check("R4", "data ack", kd, 1);
        check(liveIdx(idx) ? "R4" : "R7", "write strobe count", wrCnt - w0,
              liveIdx(idx) ? 1 : 0);
        if (liveIdx(idx)) begin
          check("R4", "write index", lastWa, idx);
          check("R4", "write data", lastWd, dat);
        end
        check("R8", "no rdClr on write", (clr0Cnt - c0) + (clr1Cnt - c1), 0);
      end
    end

    // R1: upper nibble differs
    w0 = wrCnt;
    doWrite(7'h5D, 8'h01, 8'h99, 0, ka, ki, kd, kx);
    check("R1", "wrong upper nibble ack", ka, 0);
    check("R3", "no ack after mismatch", ki | kd, 0);
    check("R3", "no write after mismatch", wrCnt - w0, 0);

    // R2: live strap pins now 000, latched value must still be 101
    doWrite(7'h18, 8'h01, 8'h99, 0, ka, ki, kd, kx);
    check("R2", "post-reset strap change ignored", ka, 0);
    check("R3", "released after strap mismatch", ki | kd, 0);

    // R10: extra byte after the data byte
    w0 = wrCnt;
    doWrite(7'h1D, 8'h02, 8'h77, 1, ka, ki, kd, kx);
    check("R10", "extra byte ack", kx, 0);
    check("R10", "single strobe", wrCnt - w0, 1);
    check("R10", "strobe data", lastWd, 8'h77);

    // R2: external reset captures a new strap value
    strap = 3'b010;
    extRstN = 0;
    repeat (4) @(negedge clk);
    check("R11", "sdaPullLow in ext reset", sdaPullLow, 0);
    extRstN = 1;
    @(negedge clk);
    strap = 3'b111;
    repeat (4) @(negedge clk);
    doRead(7'h1A, 8'h20, ka, ki, kd, b);
    check("R2", "new strap ack", ka & kd, 1);
    check("R6", "id high after ext reset", b, 8'h60);
    doWrite(7'h1D, 8'h01, 8'h55, 0, ka, ki, kd, kx);
    check("R2", "old strap no ack", ka, 0);
    doWrite(7'h1F, 8'h01, 8'h55, 0, ka, ki, kd, kx);
    check("R2", "live pins no ack", ka, 0);

    check("R9", "SDA changes while SCL high", sdaViol, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule